// File: doc/BRIEF.md
# Clock Alignment Lock Monitor

This block watches two clocks, a reference and the feedback copy coming back from an oscillator loop, and decides whether they are aligned. Both clocks are brought into a fast sampling clock domain through synchronisers. The block pairs each rising edge of one clock with the next rising edge of the other and counts the sampling ticks between them. That tick count is the gap.

A loss-of-lock flag is derived from the gaps with hysteresis. The flag is raised as soon as a gap is wider than a programmable raise threshold. It drops again only when a gap is narrower than a separate, smaller drop threshold. Once raised, the flag stays high for a minimum number of ticks, so that a short fault still produces a pulse that slower logic can see.

Every comparison that falls inside the drop window also produces a one-cycle strobe. Neighbouring logic uses the flag to detect a failed reference and the strobe as a per-cycle alignment tick. Resolution is one sampling period. The defaults assume a 1 GHz sampling clock: raise above 4 ticks, drop below 2 ticks, minimum high time 10 ticks.

Top module: `lock_window_monitor`

## Requirements
- R1: A gap strictly greater than `assert_thr` raises `loss_of_lock` (1 = unlocked). The threshold is taken from the port, so changing it moves the raise point.
- R2: `loss_of_lock` falls only after a gap strictly less than `release_thr`. A gap from `release_thr` up to `assert_thr`, inclusive, leaves the flag unchanged.
- R3: The gap is the tick count from whichever clock rises first to the rising edge of the other. Edges seen in the same tick give a gap of 0. Reference-first and feedback-first gaps are treated alike.
- R4: Each time the flag rises it stays high for at least `MIN_HIGH` ticks. A drop-qualifying comparison that arrives earlier is remembered and takes effect when the minimum time ends, unless a wide gap arrives first.
- R5: If the second edge has not arrived `TIMEOUT` ticks after the first, the comparison counts as wider than `assert_thr`. Measurement then restarts with the next edge.
- R6: During and directly after reset, `loss_of_lock` = 1 and `in_window` = 0.
- R7: `in_window` pulses for one cycle per comparison whose gap is below `release_thr`. It stays 0 for comparisons in the middle band and for wide gaps.
- R8: While the block waits for the second clock, further rising edges of the first clock are ignored. The gap is measured from the earliest unpaired edge.
- R9: Each clock input passes two synchronising flops. An input rise sampled at edge k reaches `loss_of_lock` and `in_window` at clock edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; one tick is the gap resolution |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_in | input | 1 | Reference clock, asynchronous to clk |
| fb_clk_in | input | 1 | Feedback clock, asynchronous to clk |
| assert_thr | input | CNT_W | Raise threshold in ticks (gap > value raises the flag) |
| release_thr | input | CNT_W | Drop threshold in ticks (gap < value allows the drop) |
| loss_of_lock | output | 1 | 1 = unlocked, 0 = locked |
| in_window | output | 1 | One-cycle pulse per comparison below `release_thr` |

## Verification
The hardest case to reach from the ports is a drop-qualifying comparison that lands while the minimum-high timer is still running. The stimulus reaches it by shortening the spacing between edge pairs to a few ticks: a wide pair is followed three ticks later by an aligned pair, so the drop is held pending and happens later, when the timer ends. A second hard case is the ignored repeat edge. Two reference rises are placed before one feedback rise, and the gap is chosen so that the raise or the drop decision shows which reference rise the measurement used. Timeout is reached by stopping the feedback clock for longer than the timeout window.

// File: rtl/lockdet_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the lock monitor.
// Assumes: nothing beyond standard SystemVerilog.
package lockdet_pkg;

    // Pairing state of the gap measurement.
    typedef enum logic [1:0] {
        GM_IDLE     = 2'd0,
        GM_WAIT_FB  = 2'd1,
        GM_WAIT_REF = 2'd2
    } gm_state_e;

endpackage

// File: rtl/ld_edge_sync.sv
`timescale 1ns/1ps
// Module: ld_edge_sync
// Brings one asynchronous clock into the sampling domain through STAGES flops.
// Gives a one-tick pulse when a rising edge is seen after the synchroniser.
// Assumes: the input stays high and stays low for at least two ticks each.
module ld_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain;

    // Synchroniser shift chain plus one history bit for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[DEPTH-2:0], async_in};
        end
    end

    assign rise = chain[DEPTH-2] & ~chain[DEPTH-1];

endmodule

// File: rtl/ld_gap_meter.sv
`timescale 1ns/1ps
// Module: ld_gap_meter
// Pairs each first-arriving rising edge with the next edge of the other clock.
// Reports the tick distance between them as one result, valid for one cycle.
// Gives a timeout result when the partner edge has not come within TIMEOUT ticks.
// Assumes: rise inputs are single-tick pulses from ld_edge_sync.
module ld_gap_meter
    import lockdet_pkg::*;
#(
    parameter int TIMEOUT = 64,
    parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise,
    input  logic             fb_rise,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_gap,
    output logic             meas_tmo
);
    localparam logic [CNT_W-1:0] TMO_LIMIT = CNT_W'(TIMEOUT);

    gm_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             partner_rise;

    // Select the edge that closes the current wait.
    always_comb begin
        partner_rise = (state == GM_WAIT_FB) ? fb_rise : ref_rise;
    end

    // Pairing state machine and tick counter; results are registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= GM_IDLE;
            cnt        <= '0;
            meas_valid <= 1'b0;
            meas_gap   <= '0;
            meas_tmo   <= 1'b0;
        end else begin
            meas_valid <= 1'b0;
            meas_tmo   <= 1'b0;
            case (state)
                GM_IDLE: begin
                    if (ref_rise && fb_rise) begin
                        meas_valid <= 1'b1;
                        meas_gap   <= '0;
                    end else if (ref_rise) begin
                        state <= GM_WAIT_FB;
                        cnt   <= CNT_W'(1);
                    end else if (fb_rise) begin
                        state <= GM_WAIT_REF;
                        cnt   <= CNT_W'(1);
                    end
                end
                GM_WAIT_FB, GM_WAIT_REF: begin
                    if (partner_rise) begin
                        meas_valid <= 1'b1;
                        meas_gap   <= cnt;
                        state      <= GM_IDLE;
                    end else if (cnt == TMO_LIMIT) begin
                        meas_valid <= 1'b1;
                        meas_tmo   <= 1'b1;
                        meas_gap   <= cnt;
                        state      <= GM_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= GM_IDLE;
            endcase
        end
    end

    AST_GAP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> (meas_gap <= TMO_LIMIT)); // R3
    AST_TMO_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && meas_tmo) |-> $past(state != GM_IDLE)); // R5
    AST_REPEAT_EDGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GM_WAIT_FB && ref_rise && !fb_rise && cnt != TMO_LIMIT)
        |=> (state == GM_WAIT_FB && !meas_valid)); // R8

endmodule

// File: rtl/ld_hyst_flag.sv
`timescale 1ns/1ps
// Module: ld_hyst_flag
// Turns gap results into the loss-of-lock flag, using separate raise and drop
// thresholds. Stretches each rise to MIN_HIGH ticks and gives a strobe per
// comparison inside the drop window.
// Assumes: MIN_HIGH >= 1; meas_* come straight from ld_gap_meter.
module ld_hyst_flag #(
    parameter int CNT_W    = 7,
    parameter int MIN_HIGH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_gap,
    input  logic             meas_tmo,
    input  logic [CNT_W-1:0] assert_thr,
    input  logic [CNT_W-1:0] release_thr,
    output logic             loss_of_lock,
    output logic             in_window
);
    localparam int HOLD_W = $clog2(MIN_HIGH + 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(MIN_HIGH - 1);

    logic [HOLD_W-1:0] hold_cnt;
    logic              rel_pend;
    logic              far_gap;
    logic              near_gap;

    // Classify the current comparison against both thresholds.
    always_comb begin
        far_gap  = meas_valid && (meas_tmo || (meas_gap > assert_thr));
        near_gap = meas_valid && !meas_tmo && (meas_gap < release_thr);
    end

    // Flag state, minimum-high timer, pending drop and window strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loss_of_lock <= 1'b1;
            hold_cnt     <= '0;
            rel_pend     <= 1'b0;
            in_window    <= 1'b0;
        end else begin
            in_window <= near_gap;
            if (far_gap) begin
                rel_pend <= 1'b0;
                if (!loss_of_lock) begin
                    loss_of_lock <= 1'b1;
                    hold_cnt     <= HOLD_LOAD;
                end else if (hold_cnt != '0) begin
                    hold_cnt <= hold_cnt - HOLD_W'(1);
                end
            end else if ((near_gap || rel_pend) && hold_cnt == '0) begin
                loss_of_lock <= 1'b0;
                rel_pend     <= 1'b0;
            end else begin
                if (near_gap && loss_of_lock) begin
                    rel_pend <= 1'b1;
                end
                if (hold_cnt != '0) begin
                    hold_cnt <= hold_cnt - HOLD_W'(1);
                end
            end
        end
    end

    AST_RISE_NEEDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loss_of_lock) |-> $past(meas_valid)); // R1
    AST_MID_BAND_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && !meas_tmo && meas_gap >= release_thr
         && meas_gap <= assert_thr && !loss_of_lock) |=> !loss_of_lock); // R2
    AST_HOLD_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_cnt != '0) |=> loss_of_lock); // R4
    AST_STROBE_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        in_window |-> $past(meas_valid && !meas_tmo)); // R7

endmodule

// File: rtl/lock_window_monitor.sv
`timescale 1ns/1ps
// Module: lock_window_monitor (top)
// Lock detector with hysteresis: synchronises reference and feedback clocks,
// measures the rising-edge gap in sampling ticks and drives the loss-of-lock
// flag plus a per-comparison in-window strobe.
// Assumes: clk is several times faster than either monitored clock.
module lock_window_monitor #(
    parameter int TIMEOUT     = 64,
    parameter int MIN_HIGH    = 10,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = $clog2(TIMEOUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk_in,
    input  logic             fb_clk_in,
    input  logic [CNT_W-1:0] assert_thr,
    input  logic [CNT_W-1:0] release_thr,
    output logic             loss_of_lock,
    output logic             in_window
);
    localparam int NUM_CLK = 2;

    logic [NUM_CLK-1:0] raw_clk;
    logic [NUM_CLK-1:0] clk_rise;
    logic               meas_valid;
    logic [CNT_W-1:0]   meas_gap;
    logic               meas_tmo;

    assign raw_clk = {fb_clk_in, ref_clk_in};

    // One synchroniser and edge detector per monitored clock.
    for (genvar gi = 0; gi < NUM_CLK; gi++) begin : g_sync
        ld_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_clk[gi]),
            .rise     (clk_rise[gi])
        );
    end

    ld_gap_meter #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) i_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_rise   (clk_rise[0]),
        .fb_rise    (clk_rise[1]),
        .meas_valid (meas_valid),
        .meas_gap   (meas_gap),
        .meas_tmo   (meas_tmo)
    );

    ld_hyst_flag #(.CNT_W(CNT_W), .MIN_HIGH(MIN_HIGH)) i_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .meas_valid   (meas_valid),
        .meas_gap     (meas_gap),
        .meas_tmo     (meas_tmo),
        .assert_thr   (assert_thr),
        .release_thr  (release_thr),
        .loss_of_lock (loss_of_lock),
        .in_window    (in_window)
    );

endmodule

// File: tb/test_lock_window_monitor.sv
`timescale 1ns/1ps
module test_lock_window_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int TIMEOUT    = 64;
    localparam int MIN_HIGH   = 10;
    localparam int CNT_W      = $clog2(TIMEOUT + 1);
    localparam int WATCHDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_in = 1'b0;
    logic             fb_in = 1'b0;
    logic [CNT_W-1:0] athr = CNT_W'(4);
    logic [CNT_W-1:0] rthr = CNT_W'(2);
    logic             lol;
    logic             win;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    string cur_req = "R6";

    always #(CLK_PERIOD/2) clk = ~clk;

    lock_window_monitor #(.TIMEOUT(TIMEOUT), .MIN_HIGH(MIN_HIGH)) i_lock_window_monitor (
        .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_in), .fb_clk_in(fb_in),
        .assert_thr(athr), .release_thr(rthr),
        .loss_of_lock(lol), .in_window(win)
    );

    // ---------------- behavioural reference model ----------------
    bit q1r, q2r, q3r, q1f, q2f, q3f;
    int mwait = 0;
    int mstart = 0;
    bit mv = 0, mtmo = 0;
    int mgap = 0;
    bit m_lol = 1, m_pend = 0, m_strobe = 0;
    int m_hold = 0;

    always @(posedge clk) begin
        bit er, ef, far, near, other;
        cyc++;
        if (!rst_n) begin
            {q1r, q2r, q3r, q1f, q2f, q3f} = '0;
            mwait = 0; mv = 0; mtmo = 0; mgap = 0;
            m_lol = 1; m_pend = 0; m_strobe = 0; m_hold = 0;
        end else begin
            er = q2r && !q3r;
            ef = q2f && !q3f;
            far  = mv && (mtmo || mgap > int'(athr));
            near = mv && !mtmo && mgap < int'(rthr);
            m_strobe = near;
            if (far) begin
                m_pend = 0;
                if (!m_lol) begin m_lol = 1; m_hold = MIN_HIGH - 1; end
                else if (m_hold > 0) m_hold--;
            end else if ((near || m_pend) && m_hold == 0) begin
                m_lol = 0; m_pend = 0;
            end else begin
                if (near && m_lol) m_pend = 1;
                if (m_hold > 0) m_hold--;
            end
            mv = 0; mtmo = 0;
            if (mwait == 0) begin
                if (er && ef) begin mv = 1; mgap = 0; end
                else if (er) begin mwait = 1; mstart = cyc; end
                else if (ef) begin mwait = 2; mstart = cyc; end
            end else begin
                other = (mwait == 1) ? ef : er;
                if (other) begin mv = 1; mgap = cyc - mstart; mwait = 0; end
                else if (cyc - mstart == TIMEOUT) begin mv = 1; mtmo = 1; mwait = 0; end
            end
            q3r = q2r; q2r = q1r; q1r = ref_in;
            q3f = q2f; q2f = q1f; q1f = fb_in;
        end
    end

    // ---------------- monitors ----------------
    int run_len = 0;
    int last_run = 0;
    int strobe_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (latency is R9).
    always @(negedge clk) begin
        if (!done) begin
            chk(lol === m_lol, {"R9/", cur_req}, "loss_of_lock vs model", int'(lol), int'(m_lol));
            chk(win === m_strobe, {"R9/R7/", cur_req}, "in_window vs model", int'(win), int'(m_strobe));
            if (win === 1'b1) strobe_cnt++;
            if (lol === 1'b1) run_len++;
            else begin
                if (run_len != 0) last_run = run_len;
                run_len = 0;
            end
        end
    end

    task automatic report();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > WATCHDOG && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WATCHDOG);
            report();
        end
    end

    // ---------------- stimulus ----------------
    // One window of span ticks: ref high at [dr,dr+2) and [dr2,dr2+2), fb high at [df,df+2).
    // A negative offset means no edge.
    task automatic win3(input int dr, input int dr2, input int df, input int span);
        for (int c = 0; c < span; c++) begin
            @(negedge clk);
            ref_in = (dr  >= 0 && c >= dr  && c < dr  + 2) ||
                     (dr2 >= 0 && c >= dr2 && c < dr2 + 2);
            fb_in  = (df  >= 0 && c >= df  && c < df  + 2);
        end
    endtask

    task automatic pairs(input int dr, input int df, input int span, input int n);
        for (int i = 0; i < n; i++) win3(dr, -1, df, span);
    endtask

    task automatic settle();
        win3(-1, -1, -1, 6);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        cur_req = "R6";
        chk(lol === 1'b1, "R6", "flag during reset", int'(lol), 1);
        chk(win === 1'b0, "R6", "strobe during reset", int'(win), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(lol === 1'b1, "R6", "flag after reset", int'(lol), 1);

        cur_req = "R3";
        pairs(0, 0, 12, 4); settle();
        chk(lol === 1'b0, "R3", "aligned edges lock", int'(lol), 0);

        cur_req = "R2";
        strobe_cnt = 0;
        pairs(0, 3, 12, 4); settle();
        chk(lol === 1'b0, "R2", "mid band gap 3 keeps lock", int'(lol), 0);
        chk(strobe_cnt == 0, "R7", "no strobe in mid band", strobe_cnt, 0);
        pairs(0, 4, 12, 3); settle();
        chk(lol === 1'b0, "R2", "gap equal to raise threshold keeps lock", int'(lol), 0);

        cur_req = "R1";
        pairs(0, 5, 12, 3); settle();
        chk(lol === 1'b1, "R1", "gap 5 raises flag", int'(lol), 1);

        cur_req = "R2";
        pairs(0, 2, 12, 4); settle();
        chk(lol === 1'b1, "R2", "gap equal to drop threshold keeps flag", int'(lol), 1);

        cur_req = "R3";
        strobe_cnt = 0;
        pairs(1, 0, 12, 4); settle();
        chk(lol === 1'b0, "R3", "feedback-first gap 1 locks", int'(lol), 0);
        chk(strobe_cnt == 4, "R7", "one strobe per close comparison", strobe_cnt, 4);

        cur_req = "R3";
        pairs(6, 0, 12, 3); settle();
        chk(lol === 1'b1, "R3", "feedback-first gap 6 raises", int'(lol), 1);
        pairs(0, 0, 12, 3); settle();

        cur_req = "R1";
        athr = CNT_W'(8);
        pairs(0, 6, 12, 4); settle();
        chk(lol === 1'b0, "R1", "gap 6 under raise threshold 8 keeps lock", int'(lol), 0);
        pairs(0, 9, 14, 2); settle();
        chk(lol === 1'b1, "R1", "gap 9 over raise threshold 8 raises", int'(lol), 1);
        athr = CNT_W'(4);
        pairs(0, 0, 12, 3); settle();

        cur_req = "R4";
        pairs(0, 0, 9, 2);
        win3(0, -1, 6, 9);
        pairs(0, 0, 9, 3); settle();
        chk(last_run >= MIN_HIGH, "R4", "minimum high time", last_run, MIN_HIGH);
        chk(last_run == MIN_HIGH, "R4", "deferred drop at end of hold", last_run, MIN_HIGH);
        chk(lol === 1'b0, "R4", "relocked after deferred drop", int'(lol), 0);

        cur_req = "R8";
        win3(0, 4, 6, 14); settle();
        chk(lol === 1'b1, "R8", "gap measured from first reference edge", int'(lol), 1);
        pairs(0, 0, 12, 3); settle();

        cur_req = "R5";
        pairs(0, -1, 16, 6);
        chk(lol === 1'b1, "R5", "missing feedback times out", int'(lol), 1);
        pairs(0, 0, 16, 4); settle();
        chk(lol === 1'b0, "R5", "recovery after timeout", int'(lol), 0);

        cur_req = "R6";
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(lol === 1'b1, "R6", "flag back high in reset", int'(lol), 1);
        rst_n = 1'b1;
        settle();
        report();
    end

endmodule